// File: doc/BRIEF.md
# Three-Wire Serial Configuration Loader

This block receives configuration words over a three-wire serial port (serial clock, serial data, load strobe) and keeps them in a small set of configuration banks. While the load strobe is low, each rising edge of the serial clock pushes one data bit into a 32-bit shift register, most significant bit first. When the load strobe rises, the three bits that arrived last are taken as an address. The rest of the word, 29 bits, goes into the bank that the address selects. One address does not select a bank: it returns every bank to a fixed preset image, and the banks can be written again normally after that.

The three serial pins are asynchronous to the system clock. Each pin passes through a two-stage synchronizer, and the serial clock and load strobe are edge-detected in the system clock domain. The bank outputs are therefore plain registers in that domain and can be sampled directly. Each serial pin must hold each of its levels for at least three system clock periods. Data must settle at least three periods before the serial clock rises. The block has no power-down input, so a write is accepted whenever the system clock runs.

The port carries control traffic only. There is no stream and no back-pressure: the block accepts every bit and every load strobe.

Top module: `swl_loader`

## Requirements
- R1: While reset is low, and after it is released, every bank output equals the preset image given by the PRESET_IMG parameter, with bank b at bits [b*29 +: 29].
- R2: A bit is shifted in on each rising edge of the serial clock that occurs while the load strobe is low, most significant bit first, into a 32-bit shift register.
- R3: When the load strobe rises and the low three bits of the shift register hold a value k from 1 to 4, bank k-1 takes bits [31:3] of the shift register. The other banks keep their values.
- R4: A bank changes only as a result of a load strobe rise, and it shows the new value no later than four system clock cycles after that rise. Shifting bits without a strobe rise changes no output.
- R5: Address 0 sets all banks back to the preset image. Later writes to individual banks take effect as normal.
- R6: Addresses 5, 6 and 7 change no bank.
- R7: If more or fewer than 32 bits arrive between two strobe rises, the word used is the last 32 bits received. Bits from earlier words fill the top of the register when fewer than 32 arrive.
- R8: Rising edges of the serial clock while the load strobe is high shift nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk_i | input | 1 | Serial bit clock, asynchronous |
| ser_dat_i | input | 1 | Serial data, MSB first |
| ser_le_i | input | 1 | Load strobe; low while shifting, rising edge commits the word |
| bank_o | output | 116 | Four 29-bit banks, bank b at [b*29 +: 29] |

## Verification
Nearly every internal fault shows up on bank_o within four system cycles of the next load strobe rise. Examples are a bit shifted at the wrong time, a register that misses a bit, and a wrong address decode. The fault appears as a wrong value in the addressed bank or as a change in a bank that should have stayed put. Shift-register state can be checked at the ports by sending a partial word: the resulting bank value shows which old bits stayed in the register. A premature or spurious load appears as a bank change before the strobe or with no strobe at all.

// File: rtl/swl_pkg.sv
package swl_pkg;
  // One sample of the three serial pins.
  typedef struct packed {
    logic sclk;
    logic dat;
    logic le;
  } swl_pins_t;

  // Idle levels: strobe high so that no spurious load follows reset.
  localparam swl_pins_t SWL_IDLE = '{sclk: 1'b0, dat: 1'b0, le: 1'b1};

  localparam int SWL_SYNC_STAGES = 2;
endpackage

// File: rtl/swl_sync.sv
module swl_sync
  import swl_pkg::*;
#(
  parameter int STAGES = SWL_SYNC_STAGES
) (
  input  logic      clk,
  input  logic      rst_n,
  input  swl_pins_t pins_i,
  output swl_pins_t pins_o,
  output logic      sclk_rise_o,
  output logic      le_rise_o
);
  swl_pins_t chain_q [STAGES];
  logic      sclk_prev_q;
  logic      le_prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= SWL_IDLE;
      sclk_prev_q <= SWL_IDLE.sclk;
      le_prev_q   <= SWL_IDLE.le;
    end else begin
      chain_q[0] <= pins_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
      sclk_prev_q <= chain_q[STAGES-1].sclk;
      le_prev_q   <= chain_q[STAGES-1].le;
    end
  end

  assign pins_o      = chain_q[STAGES-1];
  assign sclk_rise_o = pins_o.sclk & ~sclk_prev_q;
  assign le_rise_o   = pins_o.le & ~le_prev_q;
endmodule

// File: rtl/swl_shift.sv
module swl_shift #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] word_q;

  // Never cleared on load: the last WORD_W bits received are always held.
  always_ff @(posedge clk) begin
    if (!rst_n)          word_q <= '0;
    else if (shift_en_i) word_q <= {word_q[WORD_W-2:0], bit_i};
  end

  assign word_o = word_q;
endmodule

// File: rtl/swl_banks.sv
module swl_banks #(
  parameter int N_BANKS = 4,
  parameter int DATA_W  = 29,
  parameter int ADDR_W  = 3,
  parameter logic [N_BANKS*DATA_W-1:0] PRESET_IMG = '0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DATA_W-1:0]         data_i,
  output logic [N_BANKS*DATA_W-1:0] banks_o
);
  localparam logic [ADDR_W-1:0] ADR_PRESET = '0;

  logic preset_hit;
  assign preset_hit = load_i && (addr_i == ADR_PRESET);

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    localparam logic [ADDR_W-1:0] MY_ADR = ADDR_W'(b + 1);
    localparam logic [DATA_W-1:0] MY_PRE = PRESET_IMG[b*DATA_W +: DATA_W];

    logic              hit;
    logic [DATA_W-1:0] q;

    assign hit = load_i && (addr_i == MY_ADR);

    always_ff @(posedge clk) begin
      if (!rst_n)          q <= MY_PRE;
      else if (preset_hit) q <= MY_PRE;
      else if (hit)        q <= data_i;
    end

    assign banks_o[b*DATA_W +: DATA_W] = q;
  end
endmodule

// File: rtl/swl_loader.sv
module swl_loader
  import swl_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int ADDR_W  = 3,
  parameter int N_BANKS = 4,
  localparam int DATA_W = WORD_W - ADDR_W,
  parameter logic [N_BANKS*DATA_W-1:0] PRESET_IMG =
    {29'h1F00F00F, 29'h013579BD, 29'h0ABCDEF0, 29'h01234567}
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ser_clk_i,
  input  logic                      ser_dat_i,
  input  logic                      ser_le_i,
  output logic [N_BANKS*DATA_W-1:0] bank_o
);
  swl_pins_t         pins_raw;
  swl_pins_t         pins_s;
  logic              sclk_rise;
  logic              le_rise;
  logic              shift_en;
  logic [WORD_W-1:0] word_q;

  assign pins_raw = '{sclk: ser_clk_i, dat: ser_dat_i, le: ser_le_i};

  swl_sync #(.STAGES(SWL_SYNC_STAGES)) sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pins_i     (pins_raw),
    .pins_o     (pins_s),
    .sclk_rise_o(sclk_rise),
    .le_rise_o  (le_rise)
  );

  assign shift_en = sclk_rise & ~pins_s.le;

  swl_shift #(.WORD_W(WORD_W)) shift_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en_i(shift_en),
    .bit_i     (pins_s.dat),
    .word_o    (word_q)
  );

  swl_banks #(
    .N_BANKS   (N_BANKS),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .PRESET_IMG(PRESET_IMG)
  ) banks_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (le_rise),
    .addr_i (word_q[ADDR_W-1:0]),
    .data_i (word_q[WORD_W-1:ADDR_W]),
    .banks_o(bank_o)
  );
endmodule

// File: rtl/swl_loader_chk.sv
module swl_loader_chk #(
  parameter int WORD_W  = 32,
  parameter int ADDR_W  = 3,
  parameter int N_BANKS = 4,
  parameter int DATA_W  = 29,
  parameter logic [N_BANKS*DATA_W-1:0] PRESET_IMG = '0
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      le_rise,
  input logic [WORD_W-1:0]         word,
  input logic [N_BANKS*DATA_W-1:0] bank_o
);
  logic [ADDR_W-1:0] adr;
  assign adr = word[ADDR_W-1:0];

  AST_RESET_PRESET: assert property (@(posedge clk)
    !rst_n |=> (bank_o == PRESET_IMG)); // R1

  AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !le_rise |=> $stable(bank_o)); // R4

  AST_PRESET_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (le_rise && adr == '0) |=> (bank_o == PRESET_IMG)); // R5

  AST_BAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (le_rise && adr > ADDR_W'(N_BANKS)) |=> $stable(bank_o)); // R6

  for (genvar b = 0; b < N_BANKS; b++) begin : g_chk
    AST_BANK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (le_rise && adr == ADDR_W'(b + 1)) |=>
        (bank_o[b*DATA_W +: DATA_W] == $past(word[WORD_W-1:ADDR_W]))); // R3

    AST_BANK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (le_rise && adr != '0 && adr != ADDR_W'(b + 1)) |=>
        $stable(bank_o[b*DATA_W +: DATA_W])); // R3
  end
endmodule

bind swl_loader swl_loader_chk #(
  .WORD_W    (WORD_W),
  .ADDR_W    (ADDR_W),
  .N_BANKS   (N_BANKS),
  .DATA_W    (DATA_W),
  .PRESET_IMG(PRESET_IMG)
) chk_i (
  .clk    (clk),
  .rst_n  (rst_n),
  .le_rise(le_rise),
  .word   (word_q),
  .bank_o (bank_o)
);

// File: tb/swl_loader_tb_top.sv
module swl_loader_tb_top;
  localparam int DW = 29;
  localparam int NB = 4;
  localparam logic [NB*DW-1:0] PRE =
    {29'h1F00F00F, 29'h013579BD, 29'h0ABCDEF0, 29'h01234567};
  localparam int NV = 11;
  localparam logic [31:0] VEC [NV] = '{
    32'hDEADBEE9, 32'h12345672, 32'hCAFEF00B, 32'h0F0F0F0C,
    32'h77777775, 32'hFFFFFFFE, 32'h55555551, 32'h00000000,
    32'hA5A5A5A4, 32'h00000007, 32'h3C3C3C3B};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0;
  logic ser_dat = 1'b0;
  logic ser_le = 1'b1;
  logic [NB*DW-1:0] bank_o;

  int total = 0;
  int bad = 0;
  logic [DW-1:0] mdl [NB];

  always #10 clk = ~clk;

  swl_loader #(.PRESET_IMG(PRE)) dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk),
    .ser_dat_i(ser_dat), .ser_le_i(ser_le), .bank_o(bank_o));

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_banks(input string tag);
    for (int b = 0; b < NB; b++) chk(bank_o[b*DW +: DW], mdl[b], tag);
  endtask

  task automatic mdl_preset();
    for (int b = 0; b < NB; b++) mdl[b] = PRE[b*DW +: DW];
  endtask

  task automatic mdl_apply(input logic [31:0] w);
    if (w[2:0] == 3'd0) mdl_preset();
    else if (w[2:0] <= 3'd4) mdl[w[2:0]-1] = w[31:3];
  endtask

  task automatic ser_bit(input logic b);
    ser_dat = b;
    wait_n(4);
    ser_clk = 1'b1;
    wait_n(4);
    ser_clk = 1'b0;
  endtask

  task automatic shift_bits(input logic [39:0] w, input int n);
    ser_le = 1'b0;
    wait_n(4);
    for (int i = n - 1; i >= 0; i--) ser_bit(w[i]);
    wait_n(4);
  endtask

  task automatic strobe();
    ser_le = 1'b1;
    wait_n(6);
  endtask

  initial begin
    mdl_preset();
    wait_n(5);
    chk_banks("R1 in reset");
    rst_n = 1'b1;
    wait_n(3);
    chk_banks("R1 after reset");

    // Table walk: R2 ordering, R3 bank writes, R5 preset, R6 ignored.
    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = (VEC[v][2:0] == 3'd0) ? "R5 preset" :
            (VEC[v][2:0] > 3'd4)  ? "R6 ignored" : "R2/R3 write";
      shift_bits({8'h00, VEC[v]}, 32);
      strobe();
      mdl_apply(VEC[v]);
      chk_banks(tag);
    end

    // R4: full word shifted, no strobe yet -> nothing changes; then timing.
    shift_bits({8'h00, 32'h89ABCDE2}, 32);
    wait_n(4);
    chk_banks("R4 no strobe");
    ser_le = 1'b1;
    wait_n(1);
    chk_banks("R4 not early");
    wait_n(3);
    mdl_apply(32'h89ABCDE2);
    chk_banks("R4 within 4 cycles");

    // R7: 40 bits, last 32 used.
    shift_bits({8'hFF, 32'h2468ACE1}, 40);
    strobe();
    mdl_apply(32'h2468ACE1);
    chk_banks("R7 long word");

    // R8: clock edges while strobe high are dropped.
    ser_bit(1'b1);
    ser_bit(1'b1);
    ser_bit(1'b1);
    chk_banks("R8 no load while high");
    // R7 short word: 8 new bits on top of the held word.
    shift_bits({32'h0, 8'h5C}, 8);
    strobe();
    mdl_apply(32'h68ACE15C);
    chk_banks("R7/R8 short word");

    // R1: reset in mid-operation restores the image.
    rst_n = 1'b0;
    wait_n(3);
    mdl_preset();
    chk_banks("R1 reset again");
    rst_n = 1'b1;
    wait_n(3);
    chk_banks("R1 released");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule